// File: doc/BRIEF.md
# Stall-Aware Thread Selector

This block decides, every clock, which of several hardware threads feeding one in-order pipeline gets the issue slot. Each thread is either eligible or switched out. A thread that hits a long-latency event, such as an instruction-cache miss that keeps it waiting for about 23 cycles, raises its stall line. The selector then takes it out of the rotation by itself, with no help from software. The remaining eligible threads share its issue slots until the matching resume line brings it back.

Among the eligible threads, the slot goes to the one that issued least recently. With all four threads eligible, this gives a strict rotation in which each thread gets one quarter of the cycles. When some threads are switched out, the rest rotate among themselves and take up the freed slots. The outputs are a thread index and a valid flag. A stall raised against the thread being picked in the same cycle cancels that pick.

Top module: `stall_thread_select`

## Requirements
- R1: After reset every thread is eligible and the age order runs from thread 0 (oldest) to thread 3 (newest). The first pick after reset is thread 0 with `sel_valid_o` high.
- R2: While all four threads stay eligible, the picks follow 0,1,2,3,0,... and each thread gets exactly one slot in every four cycles.
- R3: The pick is the eligible thread that issued least recently. An issued thread becomes the most recent. The age order changes only in cycles where `sel_valid_o` is high.
- R4: A stall pulse on an eligible thread removes it from selection from the next cycle until it is resumed.
- R5: A stall pulse on the thread being picked in that same cycle forces `sel_valid_o` low for that cycle and leaves the thread's age unchanged. The next cycle goes to the oldest thread that is still eligible.
- R6: A resume pulse makes the thread eligible from the next cycle. When stall and resume arrive for one thread in the same cycle, the thread ends up switched out.
- R7: With no eligible thread, `sel_valid_o` is low.
- R8: A stall on a thread already switched out, or a resume on a thread already eligible, changes neither the eligible set nor the picks.
- R9: `sel_id_o` is the plain binary thread index 0..3 and carries meaning only while `sel_valid_o` is high.
- R10: While k threads stay eligible and no events arrive, each of them issues exactly once in every k consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 4 | Per-thread long-latency event pulse |
| resume_i | input | 4 | Per-thread completion pulse |
| sel_valid_o | output | 1 | An issue slot is granted this cycle |
| sel_id_o | output | 2 | Index of the granted thread |

## Verification
Two pairs of events can land in the same cycle. The first pair is the grant and a stall of the thread being granted. To provoke it, the bench reads the expected pick from its own age queue and raises that thread's stall line in exactly that cycle. It then expects valid low, no change in age, and the next-oldest eligible thread one cycle later. The second pair is stall and resume on one thread together, which must leave the thread switched out. Both pairs also arise by chance in a long random run in which misses end 23 cycles later, and every cycle is compared against the queue model.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
  // per-thread event pair {stall, resume}
  typedef enum logic [1:0] {
    EV_NONE   = 2'b00,
    EV_RESUME = 2'b01,
    EV_STALL  = 2'b10,
    EV_BOTH   = 2'b11
  } thr_event_e;
endpackage

// File: rtl/tsel_ready_set.sv
module tsel_ready_set
  import tsel_pkg::*;
#(
  parameter int unsigned N_THREADS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_THREADS-1:0] stall_i,
  input  logic [N_THREADS-1:0] resume_i,
  output logic [N_THREADS-1:0] ready_o
);

  for (genvar t = 0; t < N_THREADS; t++) begin : g_thr
    thr_event_e ev;
    logic       rdy_q;

    assign ev = thr_event_e'({stall_i[t], resume_i[t]});

    // stall wins over a simultaneous resume
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rdy_q <= 1'b1;
      end else begin
        case (ev)
          EV_STALL, EV_BOTH: rdy_q <= 1'b0;
          EV_RESUME:         rdy_q <= 1'b1;
          default:           rdy_q <= rdy_q;
        endcase
      end
    end

    assign ready_o[t] = rdy_q;

    a_r4_stall_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stall_i[t] |=> !ready_o[t]);

    a_r6_resume_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (resume_i[t] && !stall_i[t]) |=> ready_o[t]);

    a_r8_quiet_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!resume_i[t] && !stall_i[t]) |=> $stable(ready_o[t]));
  end

endmodule

// File: rtl/tsel_age_order.sv
module tsel_age_order #(
  parameter int unsigned N_THREADS = 4,
  parameter int unsigned IDW       = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_THREADS-1:0] ready_i,
  input  logic                 issue_i,
  output logic                 pick_valid_o,
  output logic [IDW-1:0]       pick_id_o
);

  // slot 0 = least recently issued
  logic [N_THREADS-1:0][IDW-1:0] order_q, order_d;
  logic [IDW-1:0]                pick_pos;

  always_comb begin
    pick_valid_o = 1'b0;
    pick_pos     = '0;
    for (int i = N_THREADS - 1; i >= 0; i--) begin
      if (ready_i[order_q[i]]) begin
        pick_valid_o = 1'b1;
        pick_pos     = IDW'(i);
      end
    end
  end

  assign pick_id_o = order_q[pick_pos];

  // issued entry moves to the tail, younger entries shift up
  always_comb begin
    order_d = order_q;
    if (issue_i) begin
      for (int i = 0; i < N_THREADS - 1; i++) begin
        if (i >= int'(pick_pos)) order_d[i] = order_q[i+1];
      end
      order_d[N_THREADS-1] = order_q[pick_pos];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_THREADS; i++) order_q[i] <= IDW'(i);
    end else begin
      order_q <= order_d;
    end
  end

  logic [N_THREADS-1:0] present;
  always_comb begin
    present = '0;
    for (int i = 0; i < N_THREADS; i++) present[order_q[i]] = 1'b1;
  end

  a_r3_order_perm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(present) == N_THREADS);

  a_r3_issued_moves_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |=> order_q[N_THREADS-1] == $past(pick_id_o));

  a_r3_order_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |=> $stable(order_q));

endmodule

// File: rtl/stall_thread_select.sv
module stall_thread_select #(
  parameter int unsigned N_THREADS = 4,
  localparam int unsigned IDW = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_THREADS-1:0] stall_i,
  input  logic [N_THREADS-1:0] resume_i,
  output logic                 sel_valid_o,
  output logic [IDW-1:0]       sel_id_o
);

  logic [N_THREADS-1:0] ready_q;
  logic                 pick_valid;
  logic [IDW-1:0]       pick_id;
  logic                 cancel;

  tsel_ready_set #(
    .N_THREADS(N_THREADS)
  ) u_ready (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stall_i (stall_i),
    .resume_i(resume_i),
    .ready_o (ready_q)
  );

  tsel_age_order #(
    .N_THREADS(N_THREADS),
    .IDW      (IDW)
  ) u_age (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ready_i     (ready_q),
    .issue_i     (sel_valid_o),
    .pick_valid_o(pick_valid),
    .pick_id_o   (pick_id)
  );

  // same-cycle stall of the picked thread voids the slot
  assign cancel      = pick_valid && stall_i[pick_id];
  assign sel_valid_o = pick_valid && !cancel;
  assign sel_id_o    = pick_id;

  a_r4_grant_from_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o |-> ready_q[sel_id_o]);

  a_r5_stalled_not_granted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o |-> !stall_i[sel_id_o]);

  a_r7_idle_when_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_q == '0) |-> !sel_valid_o);

  a_r10_no_repeat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o |=> (!(sel_valid_o && sel_id_o == $past(sel_id_o)) ||
                     $countones(ready_q) == 1));

endmodule

// File: tb/tb_stall_thread_select.sv
module tb_stall_thread_select;
  localparam int N = 4;
  localparam int MISS_LAT = 23;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] stall_i = '0;
  logic [N-1:0] resume_i = '0;
  logic         sel_valid_o;
  logic [1:0]   sel_id_o;

  always #4 clk = ~clk;

  stall_thread_select #(.N_THREADS(N)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .stall_i    (stall_i),
    .resume_i   (resume_i),
    .sel_valid_o(sel_valid_o),
    .sel_id_o   (sel_id_o)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    auto_en = 1'b0;
  bit    done = 1'b0;
  int    miss_cnt[N];
  int    cnt_issue[N];
  int    order_m[$];
  bit    rdy_m[N];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int model_pick();
    foreach (order_m[i]) if (rdy_m[order_m[i]]) return i;
    return -1;
  endfunction

  task automatic clear_counts();
    for (int t = 0; t < N; t++) cnt_issue[t] = 0;
  endtask

  // one cycle: drive, sample mid-cycle, advance model, move past next edge
  task automatic tick(input logic [N-1:0] st, input logic [N-1:0] rs);
    logic [N-1:0] rs_all;
    int pos;
    int tid;
    bit ev;
    rs_all = rs;
    if (auto_en) begin
      for (int t = 0; t < N; t++) begin
        if (miss_cnt[t] > 0) begin
          miss_cnt[t]--;
          if (miss_cnt[t] == 0) rs_all[t] = 1'b1;
        end
      end
    end
    stall_i  = st;
    resume_i = rs_all;
    #2;
    pos = model_pick();
    ev  = (pos >= 0) && !st[order_m[pos]];
    chk(sel_valid_o == ev, cur_req, "valid", int'(sel_valid_o), int'(ev));
    if (ev) begin
      tid = order_m[pos];
      chk(int'(sel_id_o) == tid, {cur_req, "/R9"}, "id", int'(sel_id_o), tid);
      order_m.delete(pos);
      order_m.push_back(tid);
    end
    if (sel_valid_o) cnt_issue[sel_id_o]++;
    for (int t = 0; t < N; t++) begin
      if (st[t]) begin
        if (auto_en && rdy_m[t]) miss_cnt[t] = MISS_LAT;
        rdy_m[t] = 1'b0;
      end else if (rs_all[t]) begin
        rdy_m[t] = 1'b1;
      end
    end
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    int pos;
    for (int t = 0; t < N; t++) begin
      rdy_m[t] = 1'b1;
      miss_cnt[t] = 0;
      order_m.push_back(t);
    end
    clear_counts();
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk(sel_valid_o == 1'b1, "R1", "reset valid", int'(sel_valid_o), 1);
    chk(sel_id_o == 2'd0, "R1", "reset id", int'(sel_id_o), 0);
    cur_req = "R1";
    repeat (4) tick('0, '0);

    // R2 even share with all ready
    cur_req = "R2";
    clear_counts();
    repeat (20) tick('0, '0);
    for (int t = 0; t < N; t++) chk(cnt_issue[t] == 5, "R2", "share", cnt_issue[t], 5);

    // R4 / R10 one miss, others absorb its slots
    auto_en = 1'b1;
    cur_req = "R4";
    tick(4'b0010, '0);
    clear_counts();
    cur_req = "R10";
    repeat (21) tick('0, '0);
    chk(cnt_issue[1] == 0, "R4", "stalled issues", cnt_issue[1], 0);
    chk(cnt_issue[0] == 7, "R10", "share t0", cnt_issue[0], 7);
    chk(cnt_issue[2] == 7, "R10", "share t2", cnt_issue[2], 7);
    chk(cnt_issue[3] == 7, "R10", "share t3", cnt_issue[3], 7);
    cur_req = "R6";
    repeat (6) tick('0, '0);

    // R5 stall on the thread being picked
    cur_req = "R5";
    pos = model_pick();
    tick(N'(1 << order_m[pos]), '0);
    tick('0, '0);
    pos = model_pick();
    tick(N'(1 << order_m[pos]), '0);
    repeat (30) tick('0, '0);

    // R6 / R8 event precedence and redundant events
    auto_en = 1'b0;
    cur_req = "R6";
    tick(4'b0100, 4'b0100);
    repeat (4) tick('0, '0);
    cur_req = "R8";
    tick(4'b0100, 4'b0001);
    repeat (4) tick('0, '0);
    cur_req = "R6";
    tick('0, 4'b0100);
    repeat (4) tick('0, '0);

    // R7 nobody ready
    cur_req = "R7";
    tick(4'b1111, '0);
    repeat (3) tick('0, '0);
    chk(sel_valid_o == 1'b0, "R7", "idle valid", int'(sel_valid_o), 0);
    cur_req = "R6";
    tick('0, 4'b1111);
    repeat (4) tick('0, '0);

    // R3 random misses with 23-cycle latency
    auto_en = 1'b1;
    cur_req = "R3";
    for (int k = 0; k < 400; k++) begin
      logic [N-1:0] st;
      logic [N-1:0] rs;
      for (int t = 0; t < N; t++) st[t] = ($urandom % 12) == 0;
      rs = (($urandom % 40) == 0) ? N'($urandom) : '0;
      tick(st, rs);
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL %s watchdog actual=running expected=finished", cur_req);
      summary();
      $finish;
    end
  end

endmodule